// File: doc/BRIEF.md
# Receive FIFO drain controller

This block sits on the host side of an SPI link to a packet radio. After a start pulse it pulls one packet of a known length out of the radio's 64-entry receive FIFO, using a byte-wide SPI transaction port. The radio's FIFO can hand back a duplicate when a new byte lands at the same moment as the read of its last byte. For that reason the controller never empties the FIFO while bytes are still arriving. The radio's occupancy counter can also be caught mid-update. For that reason a count is trusted only after two back-to-back reads agree.

Each pass takes a trusted count n and compares it with the bytes still owed. If n is smaller, the controller reads n-1 bytes and counts again. If n equals the remainder, it reads every remaining byte and finishes. In a second, store-then-read mode, no FIFO byte is read until the whole packet sits in the FIFO. Bytes leave on a one-cycle strobe. A one-cycle done or error pulse ends each packet.

Top module: `rxd_drain_ctrl`

## Requirements
- R1: `spi_req_o` is a one-cycle pulse, and no new request is issued while a transaction is outstanding. `spi_cmd_o`=0 reads the occupancy counter at address `COUNT_ADDR` (0x3B); `spi_cmd_o`=1 reads one FIFO byte at `FIFO_ADDR` (0x3F). The occupancy value is `spi_rdata_i[6:0]`.
- R2: A count is accepted only when two consecutive counter reads return the same value; no FIFO read follows a counter read otherwise.
- R3: In streaming mode (`wait_mode_i`=0), when an accepted count n is below the remainder, exactly n-1 bytes are read (none when n is 0 or 1), so the FIFO is never emptied while the packet is incomplete.
- R4: When the accepted count equals the remainder, all remaining bytes are read and the packet completes with exactly `pkt_len_i` FIFO reads.
- R5: In store-then-read mode (`wait_mode_i`=1), no FIFO byte is read until the accepted count equals the whole packet length.
- R6: If the fourth counter read of one acquisition still does not match the read before it, `err_o` pulses and the controller goes idle.
- R7: An accepted count above 64 or above the bytes remaining raises `err_o` without any FIFO read.
- R8: A start with length 0 or above `BUF_MAX` (200) raises `err_o` with no SPI transaction.
- R9: Each FIFO byte appears on `rx_data_o` with `rx_vld_o` high for one clock, in FIFO order.
- R10: `done_o` pulses for one clock, in the cycle after the last byte's strobe, and the controller then issues no further transactions.
- R11: `start_i` has no effect while a packet is in progress.
- R12: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin draining one packet |
| pkt_len_i | input | 8 | Expected packet length in bytes |
| wait_mode_i | input | 1 | 1: read only after the full packet is buffered |
| spi_req_o | output | 1 | One-cycle transaction request |
| spi_cmd_o | output | 1 | 0: counter read, 1: FIFO byte read |
| spi_addr_o | output | 6 | Register address for the transaction |
| spi_rdata_i | input | 8 | Read data, valid with `spi_done_i` |
| spi_done_i | input | 1 | One-cycle transaction completion |
| rx_data_o | output | 8 | Drained packet byte |
| rx_vld_o | output | 1 | Strobe for `rx_data_o` |
| done_o | output | 1 | Packet fully drained |
| err_o | output | 1 | Packet aborted |

## Verification
The assertions assume that the SPI engine returns exactly one `spi_done_i` pulse for each request, some cycles later, and never completes a transaction it was not asked for. The bench radio model keeps to this rule with a fixed five-cycle latency. It releases one byte every 16 cycles, so a counter read finishes more than twice as often as the count can change. That meets the polling-rate condition the four-read bound relies on. Only the fault-injection runs break the rate condition, and they do it on purpose by returning a forced or alternating counter value.

// File: rtl/rxd_pkg.sv
// Shared types for the receive FIFO drain controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package rxd_pkg;

    // Outcome of examining one trusted occupancy count
    typedef enum logic [1:0] {
        ACT_FAULT  = 2'd0,
        ACT_REPOLL = 2'd1,
        ACT_DRAIN  = 2'd2
    } plan_act_t;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_POLL_REQ  = 3'd1,
        S_POLL_WAIT = 3'd2,
        S_RD_REQ    = 3'd3,
        S_RD_WAIT   = 3'd4,
        S_FIN       = 3'd5
    } drain_st_t;

endpackage

// File: rtl/rxd_count_acq.sv
// Stable-count acquirer: accepts an occupancy sample only when it equals
// the sample just before it, and flags an overrun when the last allowed
// read of an acquisition still disagrees.
// Assumes: smp_vld_i is a one-cycle pulse per completed counter read;
// clear_i starts a fresh acquisition and wins over a sample.
module rxd_count_acq #(
    parameter int CNT_W     = 7,
    parameter int MAX_READS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             smp_vld_i,
    input  logic [CNT_W-1:0] smp_i,
    output logic             stable_o,
    output logic             overrun_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int RD_W = $clog2(MAX_READS + 1);

    logic [CNT_W-1:0] prev_q;
    logic             have_prev_q;
    logic [RD_W-1:0]  reads_q;
    logic             match;

    // Compare the new sample against the previous one
    always_comb begin
        match     = smp_vld_i && have_prev_q && (smp_i == prev_q);
        stable_o  = match;
        overrun_o = smp_vld_i && !match && (reads_q == RD_W'(MAX_READS - 1));
        cnt_o     = smp_i;
    end

    // Remember the last sample and how many reads this acquisition used
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            reads_q     <= '0;
        end else if (smp_vld_i) begin
            prev_q      <= smp_i;
            have_prev_q <= 1'b1;
            reads_q     <= reads_q + RD_W'(1);
        end
    end

endmodule

// File: rtl/rxd_chunk_plan.sv
// Chunk planner: from a trusted count and the bytes still owed, decides
// whether to fault, count again, or drain, and how many bytes to drain.
// Assumes: rem_i is at least 1 whenever the result is used.
module rxd_chunk_plan
    import rxd_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int LEN_W      = 8,
    parameter int FIFO_DEPTH = 64
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [LEN_W-1:0] rem_i,
    input  logic             wait_mode_i,
    output plan_act_t        act_o,
    output logic [CNT_W-1:0] chunk_o
);
    logic [LEN_W-1:0] cnt_ext;

    // Pick the action and chunk size for this count
    always_comb begin
        cnt_ext = LEN_W'(cnt_i);
        act_o   = ACT_REPOLL;
        chunk_o = '0;
        if (cnt_i > CNT_W'(FIFO_DEPTH) || cnt_ext > rem_i) begin
            act_o = ACT_FAULT;
        end else if (cnt_ext == rem_i) begin
            act_o   = ACT_DRAIN;
            chunk_o = cnt_i;
        end else if (!wait_mode_i && cnt_i >= CNT_W'(2)) begin
            act_o   = ACT_DRAIN;
            chunk_o = cnt_i - CNT_W'(1);
        end
    end

endmodule

// File: rtl/rxd_drain_ctrl.sv
// Receive FIFO drain controller: counts, plans and drains one packet
// from a remote FIFO over a byte-level SPI transaction port.
// Assumes: one spi_done_i pulse per spi_req_o, arriving at least one
// cycle after the request; the counter value sits in the low CNT_W bits.
module rxd_drain_ctrl
    import rxd_pkg::*;
#(
    parameter int LEN_W      = 8,
    parameter int CNT_W      = 7,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 64,
    parameter int BUF_MAX    = 200,
    parameter int MAX_READS  = 4,
    parameter logic [ADDR_W-1:0] COUNT_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FIFO_ADDR  = 6'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  pkt_len_i,
    input  logic              wait_mode_i,
    output logic              spi_req_o,
    output logic              spi_cmd_o,
    output logic [ADDR_W-1:0] spi_addr_o,
    input  logic [DATA_W-1:0] spi_rdata_i,
    input  logic              spi_done_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_vld_o,
    output logic              done_o,
    output logic              err_o
);
    drain_st_t        state_q;
    logic [LEN_W-1:0] rem_q;
    logic [CNT_W-1:0] left_q;
    logic             wmode_q;

    logic             acq_clr, acq_smp, acq_stable, acq_over;
    logic [CNT_W-1:0] acq_cnt, plan_chunk;
    plan_act_t        plan_act;

    // Drive the transaction port from the current state
    always_comb begin
        spi_req_o  = (state_q == S_POLL_REQ) || (state_q == S_RD_REQ);
        spi_cmd_o  = (state_q == S_RD_REQ) || (state_q == S_RD_WAIT);
        spi_addr_o = spi_cmd_o ? FIFO_ADDR : COUNT_ADDR;
        acq_smp    = spi_done_i && (state_q == S_POLL_WAIT);
        acq_clr    = (state_q == S_IDLE) || (state_q == S_RD_REQ) || acq_stable;
    end

    rxd_count_acq #(
        .CNT_W     (CNT_W),
        .MAX_READS (MAX_READS)
    ) u_acq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (acq_clr),
        .smp_vld_i (acq_smp),
        .smp_i     (spi_rdata_i[CNT_W-1:0]),
        .stable_o  (acq_stable),
        .overrun_o (acq_over),
        .cnt_o     (acq_cnt)
    );

    rxd_chunk_plan #(
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_plan (
        .cnt_i       (acq_cnt),
        .rem_i       (rem_q),
        .wait_mode_i (wmode_q),
        .act_o       (plan_act),
        .chunk_o     (plan_chunk)
    );

    // Sequencer: length check, count polling, chunked drain, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            rem_q     <= '0;
            left_q    <= '0;
            wmode_q   <= 1'b0;
            rx_data_o <= '0;
            rx_vld_o  <= 1'b0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            rx_vld_o <= 1'b0;
            done_o   <= 1'b0;
            err_o    <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        if (pkt_len_i == '0 || pkt_len_i > LEN_W'(BUF_MAX)) begin
                            err_o <= 1'b1;
                        end else begin
                            rem_q   <= pkt_len_i;
                            wmode_q <= wait_mode_i;
                            state_q <= S_POLL_REQ;
                        end
                    end
                end
                S_POLL_REQ: state_q <= S_POLL_WAIT;
                S_POLL_WAIT: begin
                    if (spi_done_i) begin
                        if (acq_over) begin
                            err_o   <= 1'b1;
                            state_q <= S_IDLE;
                        end else if (!acq_stable || plan_act == ACT_REPOLL) begin
                            state_q <= S_POLL_REQ;
                        end else if (plan_act == ACT_FAULT) begin
                            err_o   <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            left_q  <= plan_chunk;
                            state_q <= S_RD_REQ;
                        end
                    end
                end
                S_RD_REQ: state_q <= S_RD_WAIT;
                S_RD_WAIT: begin
                    if (spi_done_i) begin
                        rx_data_o <= spi_rdata_i;
                        rx_vld_o  <= 1'b1;
                        rem_q     <= rem_q - LEN_W'(1);
                        left_q    <= left_q - CNT_W'(1);
                        if (left_q != CNT_W'(1))   state_q <= S_RD_REQ;
                        else if (rem_q == LEN_W'(1)) state_q <= S_FIN;
                        else                        state_q <= S_POLL_REQ;
                    end
                end
                S_FIN: begin
                    done_o  <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxd_drain_chk.sv
// Protocol checker for the drain controller, bound to every instance.
// Assumes: the SPI engine answers each request with one done pulse.
module rxd_drain_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_req_o,
    input logic spi_cmd_o,
    input logic spi_done_i,
    input logic rx_vld_o,
    input logic done_o,
    input logic err_o
);
    logic outstanding_q;

    // Track whether a transaction is in flight
    always_ff @(posedge clk) begin
        if (!rst_n)          outstanding_q <= 1'b0;
        else if (spi_req_o)  outstanding_q <= 1'b1;
        else if (spi_done_i) outstanding_q <= 1'b0;
    end

    // R1
    one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req_o |-> !outstanding_q);
    // R1
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req_o |=> !spi_req_o);
    // R9
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld_o |=> !rx_vld_o);
    // R9
    vld_from_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld_o |-> $past(spi_done_i && spi_cmd_o));
    // R10
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rx_vld_o));
    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

endmodule

bind rxd_drain_ctrl rxd_drain_chk u_drain_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_req_o  (spi_req_o),
    .spi_cmd_o  (spi_cmd_o),
    .spi_done_i (spi_done_i),
    .rx_vld_o   (rx_vld_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/tb_rxd_drain_ctrl.sv
module tb_rxd_drain_ctrl;
    localparam int ARR = 16;
    localparam int LAT = 5;
    localparam int BUF_MAX = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] pkt_len_i = '0;
    logic       wait_mode_i = 1'b0;
    logic       spi_req_o, spi_cmd_o;
    logic [5:0] spi_addr_o;
    logic [7:0] spi_rdata_i = '0;
    logic       spi_done_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_vld_o, done_o, err_o;

    rxd_drain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pkt_len_i(pkt_len_i),
        .wait_mode_i(wait_mode_i), .spi_req_o(spi_req_o), .spi_cmd_o(spi_cmd_o),
        .spi_addr_o(spi_addr_o), .spi_rdata_i(spi_rdata_i), .spi_done_i(spi_done_i),
        .rx_data_o(rx_data_o), .rx_vld_o(rx_vld_o), .done_o(done_o), .err_o(err_o)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    int arrived, rdptr, total, cur_len, arr_tmr, seed = 0;
    int status_reads, fifo_reads, reqs, early;
    int viol_r1 = 0, viol_r2, viol_r3;
    int st_a, st_b, spi_tmr, force_mode, force_val;
    int vld_cnt, done_cnt, err_cnt;
    bit running = 0, spi_busy = 0, cur_cmd, prev_status, wmode, last_vld = 0;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 29 + seed * 7) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Radio model: byte arrivals plus the SPI transaction responder
    initial begin
        int v;
        forever begin
            @(negedge clk);
            spi_done_i = 1'b0;
            if (running) begin
                if (arr_tmr == 0) begin
                    if (arrived < total) arrived++;
                    arr_tmr = ARR - 1;
                end else arr_tmr--;
            end
            if (spi_busy) begin
                if (spi_req_o) viol_r1++;
                spi_tmr--;
                if (spi_tmr == 0) begin
                    spi_busy = 0;
                    spi_done_i = 1'b1;
                    if (!cur_cmd) begin
                        v = (force_mode == 1) ? force_val :
                            (force_mode == 2) ? 3 + (status_reads % 2) : arrived - rdptr;
                        spi_rdata_i = 8'(v);
                        st_a = st_b; st_b = v;
                        status_reads++;
                        prev_status = 1;
                    end else begin
                        spi_rdata_i = pat(rdptr);
                        rdptr++;
                        fifo_reads++;
                        if (wmode && arrived < cur_len) early++;
                        if (rdptr >= arrived && arrived < cur_len) viol_r3++;
                        if (prev_status && st_a != st_b) viol_r2++;
                        prev_status = 0;
                    end
                end
            end else if (spi_req_o) begin
                spi_busy = 1;
                spi_tmr = LAT;
                cur_cmd = spi_cmd_o;
                reqs++;
                if (spi_addr_o != (spi_cmd_o ? 6'h3F : 6'h3B)) viol_r1++;
            end
        end
    end

    // Output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rx_vld_o) begin
                    chk(rx_data_o == pat(vld_cnt), "R9", rx_data_o, pat(vld_cnt));
                    vld_cnt++;
                end
                if (done_o) begin
                    done_cnt++;
                    chk(last_vld, "R10", 0, 1);
                end
                if (err_o) err_cnt++;
                last_vld = rx_vld_o;
            end
        end
    end

    task automatic run(int len, bit wm, int fmode, int fval, bit poke);
        int cyc = 0, reqs_end;
        seed++;
        arrived = 0; rdptr = 0; total = len; cur_len = len; arr_tmr = ARR - 1;
        status_reads = 0; fifo_reads = 0; reqs = 0; early = 0;
        viol_r2 = 0; viol_r3 = 0; st_a = -1; st_b = -2; prev_status = 0;
        force_mode = fmode; force_val = fval; wmode = wm;
        vld_cnt = 0; done_cnt = 0; err_cnt = 0;
        @(negedge clk);
        running = 1;
        start_i = 1'b1; pkt_len_i = 8'(len); wait_mode_i = wm;
        @(negedge clk);
        start_i = 1'b0;
        while (done_cnt == 0 && err_cnt == 0 && cyc < 30000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 40) begin start_i = 1'b1; pkt_len_i = 8'd0; end
            if (poke && cyc == 41) start_i = 1'b0;
        end
        chk(cyc < 30000, "R10", cyc, 0);
        reqs_end = reqs;
        repeat (20) @(negedge clk);
        chk(reqs == reqs_end, "R10", reqs, reqs_end);
        running = 0;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12: outputs quiet in reset
        chk(!spi_req_o && !rx_vld_o && !done_o && !err_o, "R12",
            {spi_req_o, rx_vld_o, done_o, err_o}, 0);
        rst_n = 1'b1;

        // Streaming sweep (R2, R3, R4, R11)
        for (int l = 1; l <= 70; l++) begin
            run(l, 1'b0, 0, 0, l == 30);
            chk(done_cnt == 1 && err_cnt == 0, "R4", done_cnt, 1);
            chk(vld_cnt == l && fifo_reads == l, "R4", fifo_reads, l);
            chk(viol_r3 == 0, "R3", viol_r3, 0);
            chk(viol_r2 == 0, "R2", viol_r2, 0);
            if (l == 30) chk(err_cnt == 0 && vld_cnt == 30, "R11", vld_cnt, 30);
        end

        // Store-then-read sweep (R5)
        for (int l = 1; l <= 64; l++) begin
            run(l, 1'b1, 0, 0, 1'b0);
            chk(early == 0, "R5", early, 0);
            chk(done_cnt == 1 && vld_cnt == l, "R5", vld_cnt, l);
            chk(viol_r2 == 0, "R2", viol_r2, 0);
        end

        // R6: counter never settles
        run(20, 1'b0, 2, 0, 1'b0);
        chk(err_cnt == 1 && done_cnt == 0, "R6", err_cnt, 1);
        chk(status_reads == 4, "R6", status_reads, 4);
        chk(fifo_reads == 0, "R6", fifo_reads, 0);

        // R7: count above FIFO depth, then above remainder
        run(100, 1'b0, 1, 70, 1'b0);
        chk(err_cnt == 1 && fifo_reads == 0, "R7", fifo_reads, 0);
        run(5, 1'b1, 1, 9, 1'b0);
        chk(err_cnt == 1 && fifo_reads == 0, "R7", fifo_reads, 0);

        // R8: length rejected at start
        run(0, 1'b0, 0, 0, 1'b0);
        chk(err_cnt == 1 && reqs == 0, "R8", reqs, 0);
        run(BUF_MAX + 1, 1'b0, 0, 0, 1'b0);
        chk(err_cnt == 1 && reqs == 0, "R8", reqs, 0);
        run(BUF_MAX, 1'b0, 0, 0, 1'b0);
        chk(done_cnt == 1 && vld_cnt == BUF_MAX, "R8", vld_cnt, BUF_MAX);

        // R1: handshake and addressing over the whole run
        chk(viol_r1 == 0, "R1", viol_r1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule